// File: doc/BRIEF.md
# Three-Wire Trim Code Controller

This block turns a three-wire host interface (an active-low select, a step strobe and a direction level) into a saturating trim code that sets a digitally adjusted analog element. The three inputs are sampled with the system clock through synchronizer chains. Edges are detected on the synchronized values. While the block is selected, each falling edge of the step strobe moves the code by one position, up or down according to the direction level.

The way the host ends a session decides what is kept. If select is released while the step line is high, the current code is written into a modelled nonvolatile register, and a busy flag is held for a programmable number of cycles to stand in for the write time. If select is released while the step line is low, the register is left alone and the live code simply stays in place. A warm reset loads the stored code back into the live code. A power-on reset sets the stored code to a factory value.

Top module: `trim_ctrl`

## Requirements
- R1: While `por_n` is low, and after it is released, `code_o` equals FACTORY_CODE (default 16), `busy_o` is 0 and `standby_o` is 1. The three interface inputs idle high, and an all-high interface does nothing.
- R2: While a session is open, each high-to-low transition of `step_i` changes `code_o` by exactly one. The code goes up when `dir_up_i` is 1 and down when it is 0. The new value appears within five clock cycles.
- R3: The code saturates: a step up at 2**CODE_W-1 (31) and a step down at 0 leave the code unchanged, and the code never wraps.
- R4: While `sel_n_i` is high, `step_i` transitions have no effect on `code_o`.
- R5: `dir_up_i` may change between steps inside one session, and each step follows the level present at its own falling edge.
- R6: A rising edge of `sel_n_i` while `step_i` is high ends the session and writes the current code into the stored register, and `busy_o` rises.
- R7: A rising edge of `sel_n_i` while `step_i` is low ends the session without a write. `busy_o` stays 0 and `code_o` keeps its value.
- R8: A warm reset (`rst_n` low with `por_n` high) loads the most recently stored code into `code_o`.
- R9: `busy_o` stays high for exactly STORE_CYCLES consecutive clock cycles after a write.
- R10: A falling edge of `sel_n_i` while `busy_o` is high does not open a session. Steps are ignored until select is released and asserted again after the write.
- R11: `standby_o` is 1 exactly when no session is open and no write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; sets the stored code to the factory value |
| rst_n | input | 1 | Warm reset, active low, synchronous; recalls the stored code |
| sel_n_i | input | 1 | Select, active low, asynchronous to clk |
| step_i | input | 1 | Step strobe; acts on its falling edge |
| dir_up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| code_o | output | CODE_W | Active trim code |
| busy_o | output | 1 | Nonvolatile write in progress |
| standby_o | output | 1 | No session and no write |

## Verification
A miscounting or wrapping counter shows at `code_o` about three cycles after the step edge that caused it. The bench sweeps every code from the factory value up to the top and down to zero, so any single bad transition is caught. A wrong store decision cannot be seen at once: it shows only at the next warm reset, when the wrong code is recalled, so every session end is followed by a reset and a compare. A wrong write timer or a broken session gate shows as a busy pulse of the wrong length, or as code movement while a write is in progress.

// File: rtl/trim_pkg.sv
package trim_pkg;

   // synchronized view of the three interface pins
   typedef struct packed {
      logic sel_n;
      logic step;
      logic up;
   } ctl_t;

   // one saturating move of a code bounded by [0, top]
   function automatic int sat_next(input int cur, input bit up, input int top);
      if (up)  return (cur >= top) ? top : cur + 1;
      else     return (cur <= 0)   ? 0   : cur - 1;
   endfunction

endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] IDLE = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("trim_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n)      chain[s] <= IDLE;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/trim_counter.sv
module trim_counter #(
   parameter int CODE_W       = 5,
   parameter int FACTORY_CODE = 16
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] recall,
   input  logic              move,
   input  logic              up,
   output logic [CODE_W-1:0] code
);
   localparam int TOP = (1 << CODE_W) - 1;

   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk) begin
      if (!por_n)      code_q <= CODE_W'(FACTORY_CODE);
      else if (!rst_n) code_q <= recall;
      else if (move)   code_q <= CODE_W'(trim_pkg::sat_next(int'(code_q), up, TOP));
   end

   assign code = code_q;
endmodule

// File: rtl/trim_nvstore.sv
module trim_nvstore #(
   parameter int CODE_W       = 5,
   parameter int FACTORY_CODE = 16,
   parameter int STORE_CYCLES = 500000
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CODE_W-1:0] wdata,
   output logic [CODE_W-1:0] saved,
   output logic              busy
);
   localparam int TW = $clog2(STORE_CYCLES + 1);

   logic [CODE_W-1:0] nv_q;
   logic [TW-1:0]     left_q;
   logic              busy_q;

   // stored code survives warm reset; only power-on clears it
   always_ff @(posedge clk) begin
      if (!por_n)     nv_q <= CODE_W'(FACTORY_CODE);
      else if (start) nv_q <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!por_n || !rst_n) begin
         busy_q <= 1'b0;
         left_q <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         left_q <= TW'(STORE_CYCLES - 1);
      end else if (busy_q) begin
         if (left_q == '0) busy_q <= 1'b0;
         else              left_q <= left_q - 1'b1;
      end
   end

   assign saved = nv_q;
   assign busy  = busy_q;
endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl #(
   parameter int CODE_W       = 5,
   parameter int FACTORY_CODE = 16,
   parameter int STORE_CYCLES = 500000,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              sel_n_i,
   input  logic              step_i,
   input  logic              dir_up_i,
   output logic [CODE_W-1:0] code_o,
   output logic              busy_o,
   output logic              standby_o
);
   import trim_pkg::*;

   localparam int NIN = $bits(ctl_t);

   generate
      if (CODE_W < 1) begin : g_bad_w
         $error("trim_ctrl: CODE_W must be positive");
      end
      if (FACTORY_CODE < 0 || FACTORY_CODE >= (1 << CODE_W)) begin : g_bad_f
         $error("trim_ctrl: FACTORY_CODE out of range");
      end
      if (STORE_CYCLES < 1) begin : g_bad_s
         $error("trim_ctrl: STORE_CYCLES must be positive");
      end
   endgenerate

   logic rst_all_n;
   assign rst_all_n = rst_n & por_n;

   logic [NIN-1:0] synced;
   ctl_t           ctl;

   trim_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES), .IDLE('1)) u_sync (
      .clk   (clk),
      .rst_n (rst_all_n),
      .d     ({sel_n_i, step_i, dir_up_i}),
      .q     (synced)
   );
   assign ctl = ctl_t'(synced);

   // previous synchronized levels for edge detection
   logic sel_n_d, step_d;
   always_ff @(posedge clk) begin
      if (!rst_all_n) begin
         sel_n_d <= 1'b1;
         step_d  <= 1'b1;
      end else begin
         sel_n_d <= ctl.sel_n;
         step_d  <= ctl.step;
      end
   end

   logic sel_fall, sel_rise, step_fall;
   assign sel_fall  =  sel_n_d & ~ctl.sel_n;
   assign sel_rise  = ~sel_n_d &  ctl.sel_n;
   assign step_fall =  step_d  & ~ctl.step;

   logic busy;
   logic session_q;
   always_ff @(posedge clk) begin
      if (!rst_all_n)                session_q <= 1'b0;
      else if (sel_rise)             session_q <= 1'b0;
      else if (sel_fall && !busy)    session_q <= 1'b1;
   end

   logic move, store_go;
   assign move     = session_q & ~ctl.sel_n & step_fall;
   assign store_go = session_q & sel_rise & ctl.step;

   logic [CODE_W-1:0] code, saved;

   trim_counter #(.CODE_W(CODE_W), .FACTORY_CODE(FACTORY_CODE)) u_cnt (
      .clk    (clk),
      .por_n  (por_n),
      .rst_n  (rst_n),
      .recall (saved),
      .move   (move),
      .up     (ctl.up),
      .code   (code)
   );

   trim_nvstore #(.CODE_W(CODE_W), .FACTORY_CODE(FACTORY_CODE),
                  .STORE_CYCLES(STORE_CYCLES)) u_nv (
      .clk   (clk),
      .por_n (por_n),
      .rst_n (rst_n),
      .start (store_go),
      .wdata (code),
      .saved (saved),
      .busy  (busy)
   );

   assign code_o    = code;
   assign busy_o    = busy;
   assign standby_o = ~session_q & ~busy;
endmodule

// File: rtl/trim_ctrl_chk.sv
module trim_ctrl_chk #(
   parameter int CODE_W = 5
) (
   input logic              clk,
   input logic              por_n,
   input logic              rst_n,
   input logic [CODE_W-1:0] code_o,
   input logic              busy_o,
   input logic              standby_o
);
   localparam int TOP = (1 << CODE_W) - 1;

   logic live;
   assign live = por_n & rst_n;

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!live)
      $past(live) |-> ((int'(code_o) - int'($past(code_o)) <= 1) &&
                       (int'($past(code_o)) - int'(code_o) <= 1))) // R2
      else $error("code moved by more than one");

   AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!live)
      ($past(live) && int'($past(code_o)) == TOP) |-> int'(code_o) >= TOP - 1) // R3
      else $error("code wrapped at top");

   AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!live)
      ($past(live) && $past(code_o) == '0) |-> int'(code_o) <= 1) // R3
      else $error("code wrapped at bottom");

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!live)
      ($past(live) && $past(standby_o)) |-> $stable(code_o)) // R4
      else $error("code moved while idle");

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!live)
      ($past(live) && $past(busy_o)) |-> $stable(code_o)) // R10
      else $error("code moved during write");

   AST_WRITE_FROM_SESSION: assert property (@(posedge clk) disable iff (!live)
      ($past(live) && $rose(busy_o)) |-> !$past(standby_o)) // R6
      else $error("write started without a session");

   AST_STANDBY_EXCL: assert property (@(posedge clk) disable iff (!live)
      busy_o |-> !standby_o) // R11
      else $error("standby during write");
endmodule

bind trim_ctrl trim_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .rst_n     (rst_n),
   .code_o    (code_o),
   .busy_o    (busy_o),
   .standby_o (standby_o)
);

// File: tb/trim_ctrl_tb_top.sv
`timescale 1ns/1ps
module trim_ctrl_tb_top;
   localparam int CW   = 5;
   localparam int FACT = 16;
   localparam int SC   = 16;
   localparam int TOP  = (1 << CW) - 1;

   logic clk = 1'b0;
   logic por_n = 1'b0, rst_n = 1'b0;
   logic sel_n = 1'b1, step = 1'b1, up = 1'b1;
   logic [CW-1:0] code;
   logic busy, standby;

   int tests = 0, fails = 0;
   int model;

   always #5 clk = ~clk;

   trim_ctrl #(.CODE_W(CW), .FACTORY_CODE(FACT), .STORE_CYCLES(SC), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .sel_n_i(sel_n), .step_i(step),
      .dir_up_i(up), .code_o(code), .busy_o(busy), .standby_o(standby));

   task automatic chk(input int act, input int exp, input string req);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one step edge; model follows the saturating rule
   task automatic pulse(input bit dir, input bit counts);
      up = dir;
      wait_n(3);
      step = 1'b0;
      wait_n(5);
      step = 1'b1;
      wait_n(4);
      if (counts) model = dir ? ((model >= TOP) ? TOP : model + 1)
                              : ((model <= 0) ? 0 : model - 1);
   endtask

   task automatic warm_reset();
      rst_n = 1'b0;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(3);
   endtask

   task automatic open_session();
      sel_n = 1'b0;
      wait_n(5);
   endtask

   // release with step high and measure the busy pulse
   task automatic store_release(output int busy_len);
      int waited;
      busy_len = 0;
      waited   = 0;
      sel_n = 1'b1;
      while (!busy && waited < 20) begin wait_n(1); waited++; end
      while (busy && busy_len < 200) begin wait_n(1); busy_len++; end
      wait_n(2);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      int blen;
      wait_n(4);
      chk(int'(code), FACT, "R1 code during power-on");
      por_n = 1'b1;
      wait_n(2);
      rst_n = 1'b1;
      wait_n(6);
      model = FACT;
      chk(int'(code), FACT, "R1 code after power-on");
      chk(int'(busy), 0, "R1 busy after power-on");
      chk(int'(standby), 1, "R1 standby after power-on");

      // R4: steps while deselected
      for (int i = 0; i < 3; i++) begin
         pulse(1'b1, 1'b0);
         chk(int'(code), FACT, "R4 step while deselected");
      end

      open_session();
      chk(int'(standby), 0, "R11 standby low in session");

      // R2/R3: sweep up past the top
      for (int i = 0; i < 20; i++) begin
         pulse(1'b1, 1'b1);
         chk(int'(code), model, "R2 R3 step up");
      end
      chk(int'(code), TOP, "R3 saturates at top");

      // R5: change direction in the same session, sweep past zero
      for (int i = 0; i < 40; i++) begin
         pulse(1'b0, 1'b1);
         chk(int'(code), model, "R5 R3 step down");
      end
      chk(int'(code), 0, "R3 saturates at zero");

      for (int i = 0; i < 7; i++) pulse(1'b1, 1'b1);
      chk(int'(code), 7, "R2 climb to 7");

      // R6/R9: store on release with step high
      store_release(blen);
      chk(blen, SC, "R9 busy length");
      chk(int'(standby), 1, "R11 standby after write");
      chk(int'(code), 7, "R6 code kept after write");

      // R7: release with step low, no write
      open_session();
      for (int i = 0; i < 3; i++) pulse(1'b1, 1'b1);
      up = 1'b1;
      wait_n(2);
      step = 1'b0;
      wait_n(5);
      model = model + 1;
      sel_n = 1'b1;
      begin
         int seen = 0;
         for (int i = 0; i < 30; i++) begin
            wait_n(1);
            if (busy) seen = 1;
         end
         chk(seen, 0, "R7 no busy on release with step low");
      end
      step = 1'b1;
      wait_n(4);
      chk(int'(code), 11, "R7 live code kept");

      // R8: warm reset recalls the stored value, not the live one
      warm_reset();
      chk(int'(code), 7, "R8 recall after warm reset");
      chk(int'(standby), 1, "R11 standby after warm reset");

      // R10: select during busy is ignored
      model = 7;
      open_session();
      pulse(1'b1, 1'b1);
      pulse(1'b1, 1'b1);
      chk(int'(code), 9, "R2 climb to 9");
      sel_n = 1'b1;
      wait_n(6);
      chk(int'(busy), 1, "R6 busy after store release");
      sel_n = 1'b0;
      wait_n(2);
      pulse(1'b1, 1'b0);
      chk(int'(code), 9, "R10 step during busy ignored");
      wait_n(SC + 4);
      chk(int'(busy), 0, "R9 busy ended");
      pulse(1'b1, 1'b0);
      chk(int'(code), 9, "R10 step after busy without new select ignored");
      chk(int'(standby), 1, "R11 standby with stale select");
      sel_n = 1'b1;
      wait_n(30);
      chk(int'(busy), 0, "R10 release of stale select does not write");
      open_session();
      pulse(1'b1, 1'b1);
      chk(int'(code), 10, "R10 fresh session counts again");
      up = 1'b0;
      wait_n(3);
      step = 1'b0;
      wait_n(5);
      sel_n = 1'b1;
      wait_n(5);
      step = 1'b1;
      wait_n(4);
      warm_reset();
      chk(int'(code), 9, "R8 recall keeps the second write");

      // R1: power-on restores factory value
      por_n = 1'b0;
      rst_n = 1'b0;
      wait_n(3);
      por_n = 1'b1;
      wait_n(2);
      rst_n = 1'b1;
      wait_n(4);
      chk(int'(code), FACT, "R1 factory value after power cycle");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule